// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits on the controller side of an asynchronous 16-bit NAND flash bus. It takes one host request at a time and runs one of three operations on the flash pins: a page read, a block erase, or a status read. A request carries an operation code, a 16-bit row (page) address, an 11-bit column (word) address and a word count. It is accepted by a one-cycle `start` pulse while the block is idle.

The block drives chip enable, the command latch strobe, the address latch strobe, the write strobe and the read strobe. It also drives a 16-bit output bus with an enable, and it samples the ready/busy line from the flash. Every bus timing is set by a parameter in nanoseconds, which is turned into a clock count at elaboration. Read words and the status word leave through a valid/ready stream. At the end of each operation `done` pulses for one cycle, and for an erase or a status read `fail` reports the pass/fail bit.

The controller is one state machine with these states:
- `S_PWR`: waits out power-up.
- `S_IDLE`: waits for a request.
- `S_WE_LO` / `S_WE_HI`: the low and high halves of a bus write cycle, for a command or address byte.
- `S_WAIT_RB`: waits for the flash to report ready.
- `S_TAR`: bus turnaround gap before a read strobe.
- `S_RE_LO` / `S_RE_HI`: the low and high halves of a read strobe.
- `S_PUSH`: offers a word on the stream.
- `S_DONE`: the completion cycle.

The transitions are:
- PWR to IDLE when the power-up timer expires.
- IDLE to WE_LO on an accepted start.
- WE_LO to WE_HI, and WE_HI back to WE_LO while bytes of the current step list remain.
- After the last byte of a step list, WE_HI goes to WAIT_RB for read and erase, and to TAR for status.
- WAIT_RB goes to TAR for a read. For an erase it goes to WE_LO, which starts the status command.
- TAR to RE_LO, and RE_LO to RE_HI.
- From RE_HI: an erase returns to RE_LO while status bit 6 is 0 and goes to DONE once it is 1. Read and status go to PUSH.
- PUSH goes to RE_LO for the next read word, or to DONE.
- DONE to IDLE.

Top module: `nand_seq`

## Requirements
- R1: After reset is released, `busy` stays high and chip enable stays high (deselected) for exactly ceil(T_PWR_NS/CLK_NS) cycles, 500 by default. No write or read strobe occurs in that time. `busy` then falls, and chip enable is high whenever `busy` is low.
- R2: A page read (op code 0) writes command 00h with the command latch high, then four address bytes with the address latch high, then command 30h. The address bytes are, in order: column[7:0]; column[10:8] in bits 2..0 with bits 7..3 zero; row[7:0]; row[15:8].
- R3: During every command and address write cycle the output enable is high and bus bits 15..8 are zero. Successive falling edges of the write strobe are at least 45 ns apart.
- R4: After a command that starts an array operation (30h or D0h), no read strobe falls until ready/busy has been seen high.
- R5: A read returns words from column address `col` upward, in order, one word for each read strobe, on the stream. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold, and no new read strobe starts.
- R6: A read transfers `count` words, with a count of zero treated as one. The transfer stops after column 1055 even when words remain.
- R7: A block erase (op code 1) writes 60h, row[7:0], row[15:8] and D0h. After ready, it writes 70h and reads status, and `fail` takes status bit 0 (1 = fail).
- R8: An erase completes only when a status read returns bit 6 = 1. While bit 6 reads 0, the read strobe is repeated with no new command.
- R9: A status read (op code 2) writes 70h, strobes read once, and passes {8'h00, status[7:0]} on the stream, so the upper byte of the bus is dropped. `fail` takes status bit 0.
- R10: A `start` while `busy` is high is ignored. So is op code 3. Neither puts any write cycle on the bus.
- R11: The command latch and the address latch strobes are never high together. The output enable is low whenever the read strobe is low. At least 10 ns pass from the last latch strobe falling to a read strobe falling.
- R12: `done` is high for exactly one cycle per operation, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 0 read, 1 erase, 2 status, 3 ignored |
| row | input | 16 | Page address (block in bits 15..6) |
| col | input | 11 | First column word |
| count | input | 11 | Words to read (0 means 1) |
| rd_data | output | 16 | Stream word |
| rd_valid | output | 1 | Stream word valid |
| rd_ready | input | 1 | Stream sink ready |
| busy | output | 1 | Operation or power-up wait in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last status bit 0 |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 16 | Bus value driven to the flash |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 16 | Bus value from the flash |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
A wrong step index or step list shows on the very next write-strobe edge as a wrong byte or a wrong latch strobe, and the flash model logs it. A bad exit from the ready wait or the turnaround state shows in the same cycle as a read strobe that falls while the flash is busy, or too soon after a latch strobe. A miscounted column or word count appears as a wrong stream word or wrong word total by the end of the transfer. A stuck status loop or a lost `fail` bit shows as a wrong strobe count or a wrong `fail` at the `done` pulse.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_ERASE  = 2'd1,
        OP_STATUS = 2'd2,
        OP_NONE   = 2'd3
    } nfc_op_e;

    typedef enum logic [3:0] {
        S_PWR, S_IDLE, S_WE_LO, S_WE_HI, S_WAIT_RB,
        S_TAR, S_RE_LO, S_RE_HI, S_PUSH, S_DONE
    } nfc_state_e;

    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS   = 8'h70;

    // round a nanosecond figure up to whole clocks, never below one
    function automatic int ns_to_clk(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/nfc_timer.sv
`timescale 1ns/1ps
module nfc_timer #(
    parameter int W       = 10,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= W'(RST_VAL);
        else if (load)           cnt_q <= val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nfc_step_sel.sv
`timescale 1ns/1ps
module nfc_step_sel
    import nfc_pkg::*;
#(
    parameter int COL_W = 11,
    parameter int ROW_W = 16
) (
    input  nfc_op_e          mode,
    input  logic [2:0]       idx,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    output logic [7:0]       bus_byte,
    output logic             is_cmd,
    output logic             is_addr,
    output logic             is_last
);
    logic [15:0] col_x, row_x;
    assign col_x = 16'(col);
    assign row_x = 16'(row);

    always_comb begin
        bus_byte = CMD_STATUS;
        is_cmd   = 1'b1;
        is_addr  = 1'b0;
        is_last  = 1'b0;
        unique case (mode)
            OP_READ: begin
                unique case (idx)
                    3'd0: bus_byte = CMD_RD_SETUP;
                    3'd1: begin bus_byte = col_x[7:0];  is_cmd = 1'b0; is_addr = 1'b1; end
                    3'd2: begin bus_byte = col_x[15:8]; is_cmd = 1'b0; is_addr = 1'b1; end
                    3'd3: begin bus_byte = row_x[7:0];  is_cmd = 1'b0; is_addr = 1'b1; end
                    3'd4: begin bus_byte = row_x[15:8]; is_cmd = 1'b0; is_addr = 1'b1; end
                    default: begin bus_byte = CMD_RD_GO; is_last = 1'b1; end
                endcase
            end
            OP_ERASE: begin
                unique case (idx)
                    3'd0: bus_byte = CMD_ER_SETUP;
                    3'd1: begin bus_byte = row_x[7:0];  is_cmd = 1'b0; is_addr = 1'b1; end
                    3'd2: begin bus_byte = row_x[15:8]; is_cmd = 1'b0; is_addr = 1'b1; end
                    default: begin bus_byte = CMD_ER_GO; is_last = 1'b1; end
                endcase
            end
            default: is_last = 1'b1;
        endcase
    end
endmodule

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
module nand_seq
    import nfc_pkg::*;
#(
    parameter int CLK_NS     = 20,
    parameter int T_WP_NS    = 25,
    parameter int T_WH_NS    = 20,
    parameter int T_REA_NS   = 30,
    parameter int T_REH_NS   = 10,
    parameter int T_AR_NS    = 10,
    parameter int T_WB_NS    = 100,
    parameter int T_PWR_NS   = 10000,
    parameter int PAGE_WORDS = 1056,
    parameter int COL_W      = 11,
    parameter int ROW_W      = 16,
    parameter int DW         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] count,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [DW-1:0]    nand_io_out,
    output logic             nand_io_oe,
    input  logic [DW-1:0]    nand_io_in,
    input  logic             nand_rb_n
);
    localparam int C_WP  = ns_to_clk(T_WP_NS, CLK_NS);
    localparam int C_WH  = ns_to_clk(T_WH_NS, CLK_NS);
    localparam int C_REA = ns_to_clk(T_REA_NS, CLK_NS);
    localparam int C_REH = ns_to_clk(T_REH_NS, CLK_NS);
    localparam int C_AR  = ns_to_clk(T_AR_NS, CLK_NS);
    localparam int C_WB  = ns_to_clk(T_WB_NS, CLK_NS);
    localparam int C_PWR = ns_to_clk(T_PWR_NS, CLK_NS);
    localparam int TW    = $clog2(C_PWR + C_WB + C_WP + C_WH + C_REA + C_REH + C_AR + 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_WORDS - 1);

    nfc_state_e       state_q, state_d;
    nfc_op_e          op_q, mode_q;
    logic [2:0]       idx_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q, left_q;
    logic [DW-1:0]    data_q;
    logic             fail_q;

    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic [7:0]       step_byte;
    logic             step_cmd, step_addr, step_last;
    logic             accept, last_word;

    nfc_timer #(.W(TW), .RST_VAL(C_PWR - 1)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    nfc_step_sel #(.COL_W(COL_W), .ROW_W(ROW_W)) step_i (
        .mode(mode_q), .idx(idx_q), .col(col_q), .row(row_q),
        .bus_byte(step_byte), .is_cmd(step_cmd), .is_addr(step_addr), .is_last(step_last)
    );

    assign accept    = (state_q == S_IDLE) && start && (nfc_op_e'(op) != OP_NONE);
    assign last_word = (left_q == COL_W'(1)) || (col_q == COL_LAST);

    // next state and timer reload
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_PWR:   if (tmr_zero) state_d = S_IDLE;
            S_IDLE:  if (accept) begin
                state_d = S_WE_LO; tmr_load = 1'b1; tmr_val = TW'(C_WP - 1);
            end
            S_WE_LO: if (tmr_zero) begin
                state_d = S_WE_HI; tmr_load = 1'b1; tmr_val = TW'(C_WH - 1);
            end
            S_WE_HI: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (!step_last) begin
                    state_d = S_WE_LO; tmr_val = TW'(C_WP - 1);
                end else if (mode_q == OP_STATUS) begin
                    state_d = S_TAR; tmr_val = TW'(C_AR - 1);
                end else begin
                    state_d = S_WAIT_RB; tmr_val = TW'(C_WB - 1);
                end
            end
            S_WAIT_RB: if (tmr_zero && nand_rb_n) begin
                tmr_load = 1'b1;
                if (op_q == OP_READ) begin
                    state_d = S_TAR; tmr_val = TW'(C_AR - 1);
                end else begin
                    state_d = S_WE_LO; tmr_val = TW'(C_WP - 1);
                end
            end
            S_TAR: if (tmr_zero) begin
                state_d = S_RE_LO; tmr_load = 1'b1; tmr_val = TW'(C_REA - 1);
            end
            S_RE_LO: if (tmr_zero) begin
                state_d = S_RE_HI; tmr_load = 1'b1; tmr_val = TW'(C_REH - 1);
            end
            S_RE_HI: if (tmr_zero) begin
                if (op_q != OP_ERASE)  state_d = S_PUSH;
                else if (data_q[6])    state_d = S_DONE;
                else begin
                    state_d = S_RE_LO; tmr_load = 1'b1; tmr_val = TW'(C_REA - 1);
                end
            end
            S_PUSH: if (rd_ready) begin
                if (op_q == OP_READ && !last_word) begin
                    state_d = S_RE_LO; tmr_load = 1'b1; tmr_val = TW'(C_REA - 1);
                end else begin
                    state_d = S_DONE;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_PWR;
        else        state_q <= state_d;
    end

    // request, step and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_READ; mode_q <= OP_READ; idx_q <= '0;
            row_q <= '0; col_q <= '0; left_q <= '0; data_q <= '0; fail_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= nfc_op_e'(op);
                mode_q <= nfc_op_e'(op);
                idx_q  <= '0;
                row_q  <= row;
                col_q  <= col;
                left_q <= (count == '0) ? COL_W'(1) : count;
            end
            if (state_q == S_WE_HI && tmr_zero && !step_last)
                idx_q <= idx_q + 3'd1;
            if (state_q == S_WAIT_RB && tmr_zero && nand_rb_n && op_q == OP_ERASE) begin
                mode_q <= OP_STATUS;
                idx_q  <= '0;
            end
            if (state_q == S_RE_LO && tmr_zero)
                data_q <= nand_io_in;
            if (state_q == S_RE_HI && tmr_zero &&
                (op_q == OP_STATUS || (op_q == OP_ERASE && data_q[6])))
                fail_q <= data_q[0];
            if (state_q == S_PUSH && rd_ready && op_q == OP_READ) begin
                col_q  <= col_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    // pin and host outputs
    always_comb begin
        nand_ce_n   = (state_q == S_PWR) || (state_q == S_IDLE) || (state_q == S_DONE);
        nand_io_oe  = (state_q == S_WE_LO) || (state_q == S_WE_HI);
        nand_cle    = nand_io_oe && step_cmd;
        nand_ale    = nand_io_oe && step_addr;
        nand_we_n   = (state_q != S_WE_LO);
        nand_re_n   = (state_q != S_RE_LO);
        nand_io_out = nand_io_oe ? DW'(step_byte) : '0;
        rd_valid    = (state_q == S_PUSH);
        rd_data     = (op_q == OP_STATUS) ? DW'(data_q[7:0]) : data_q;
        busy        = (state_q != S_IDLE);
        done        = (state_q == S_DONE);
        fail        = fail_q;
    end
endmodule

// File: rtl/nand_seq_chk.sv
`timescale 1ns/1ps
module nand_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nand_ce_n,
    input logic          nand_cle,
    input logic          nand_ale,
    input logic          nand_we_n,
    input logic          nand_re_n,
    input logic          nand_io_oe,
    input logic [DW-1:0] nand_io_out,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          busy,
    input logic          done
);
    assert_latch_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    assert_hi_byte_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nand_io_oe |-> (nand_io_out[DW-1:8] == '0));

    assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> nand_ce_n);

    assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
endmodule

bind nand_seq nand_seq_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_oe(nand_io_oe), .nand_io_out(nand_io_out), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy), .done(done)
);

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb_top;
    localparam int RD_BUSY = 25;
    localparam int ER_BUSY = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] row = '0;
    logic [10:0] col = '0;
    logic [10:0] count = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic        busy, done, fail;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [15:0] nand_io_out;
    logic [15:0] m_io = 16'h0000;
    logic        nand_rb_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nand_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .row(row), .col(col),
        .count(count), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .busy(busy), .done(done), .fail(fail), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(m_io), .nand_rb_n(nand_rb_n)
    );

    // ---------------- flash model and bus monitors ----------------
    int        busy_left = 0;
    assign nand_rb_n = (busy_left == 0);
    logic [7:0]  wr_byte [64];
    logic        wr_cmd  [64];
    logic        wr_adr  [64];
    int          wr_n = 0;
    logic [7:0]  a_b [4];
    int          a_n = 0;
    logic [15:0] m_row = '0;
    logic [10:0] m_col = '0;
    bit          stat_mode = 1'b0;
    int          stat_reads = 0;
    int          stat_lag = 0;
    bit          m_fail = 1'b0;
    int          re_cnt = 0;
    int          hi_viol = 0, tim_viol = 0, both_ctl = 0, oe_re = 0, re_early = 0, ar_viol = 0;
    time         last_wf = 0;
    time         last_ctl = 0;

    function automatic logic [15:0] pat(input logic [15:0] r, input logic [10:0] c);
        return {r[4:0], c} ^ 16'h5A3C;
    endfunction

    always @(posedge clk) if (busy_left > 0) busy_left = busy_left - 1;

    always @(posedge nand_we_n) if (rst_n && !nand_ce_n) begin
        if (wr_n < 64) begin
            wr_byte[wr_n] = nand_io_out[7:0];
            wr_cmd[wr_n]  = nand_cle;
            wr_adr[wr_n]  = nand_ale;
            wr_n = wr_n + 1;
        end
        if (nand_io_out[15:8] != 8'h00 || !nand_io_oe) hi_viol = hi_viol + 1;
        if (nand_cle) begin
            case (nand_io_out[7:0])
                8'h00, 8'h60: a_n = 0;
                8'h30: begin
                    m_col = {a_b[1][2:0], a_b[0]};
                    m_row = {a_b[3], a_b[2]};
                    busy_left = RD_BUSY;
                    stat_mode = 1'b0;
                end
                8'hD0: busy_left = ER_BUSY;
                8'h70: begin stat_mode = 1'b1; stat_reads = 0; end
                default: ;
            endcase
        end else if (nand_ale) begin
            if (a_n < 4) a_b[a_n] = nand_io_out[7:0];
            a_n = a_n + 1;
        end
    end

    always @(negedge nand_we_n) if (rst_n && !nand_ce_n) begin
        if (last_wf != 0 && ($time - last_wf) < 45) tim_viol = tim_viol + 1;
        last_wf = $time;
    end

    always @(negedge nand_cle) last_ctl = $time;
    always @(negedge nand_ale) last_ctl = $time;

    always @(negedge clk) if (rst_n) begin
        if (nand_cle && nand_ale) both_ctl = both_ctl + 1;
        if (!nand_re_n && nand_io_oe) oe_re = oe_re + 1;
    end

    always @(negedge nand_re_n) if (rst_n) begin
        re_cnt = re_cnt + 1;
        if (!nand_rb_n) re_early = re_early + 1;
        if (nand_io_oe) oe_re = oe_re + 1;
        if (($time - last_ctl) < 10) ar_viol = ar_viol + 1;
        m_io = 16'hDEAD;
        #30;
        if (stat_mode) begin
            stat_reads = stat_reads + 1;
            m_io = {8'hC3, 1'b0, (stat_reads > stat_lag), 5'b00000, m_fail};
        end else begin
            m_io = pat(m_row, m_col);
            m_col = m_col + 11'd1;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    int          rx_n, rx_bad, hold_bad, done_cnt;
    logic [15:0] rx_last;

    task automatic start_op(input logic [1:0] o, input logic [15:0] r,
                            input logic [10:0] c, input logic [10:0] n);
        wr_n = 0; re_cnt = 0;
        @(negedge clk);
        start = 1'b1; op = o; row = r; col = c; count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic collect(input logic [15:0] r, input logic [10:0] c, input bit stall);
        bit          rdy;
        bit          held;
        logic [15:0] held_val;
        rx_n = 0; rx_bad = 0; hold_bad = 0; done_cnt = 0; held = 1'b0; rdy = 1'b0;
        held_val = '0;
        for (int k = 0; k < 20000; k++) begin
            if (held) begin
                if (!rd_valid || rd_data != held_val) hold_bad = hold_bad + 1;
                held = 1'b0;
            end
            if (done) done_cnt = done_cnt + 1;
            if (done_cnt > 0 && !done) break;
            rdy = stall ? ~rdy : 1'b1;
            rd_ready = rdy;
            if (rd_valid && rdy) begin
                rx_last = rd_data;
                if (op == 2'd0 && rd_data != pat(r, c + 11'(rx_n))) rx_bad = rx_bad + 1;
                rx_n = rx_n + 1;
            end else if (rd_valid) begin
                held = 1'b1; held_val = rd_data;
            end
            @(negedge clk);
        end
        rd_ready = 1'b0;
        check(done_cnt == 1, "R12 done width", done_cnt, 1);
        check(!busy, "R12 busy after done", busy, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_powerup();
        int cyc;
        cyc = 0;
        check(busy && nand_ce_n, "R1 reset state busy/ce", {busy, nand_ce_n}, 2'b11);
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc = cyc + 1;
        end
        check(cyc == 10000 / 20, "R1 power-up cycles", cyc, 10000 / 20);
        check(wr_n == 0 && re_cnt == 0, "R1 no strobes in power-up", wr_n + re_cnt, 0);
        check(nand_ce_n, "R1 deselected when idle", nand_ce_n, 1);
    endtask

    task automatic t_read(input logic [15:0] r, input logic [10:0] c,
                          input logic [10:0] n, input bit stall, input string tag);
        int exp_n;
        exp_n = (n == 0) ? 1 : int'(n);
        if (int'(c) + exp_n > 1056) exp_n = 1056 - int'(c);
        start_op(2'd0, r, c, n);
        collect(r, c, stall);
        check(wr_n == 6, {tag, " R2 write count"}, wr_n, 6);
        check(wr_cmd[0] && wr_byte[0] == 8'h00, {tag, " R2 setup cmd"}, wr_byte[0], 8'h00);
        check(wr_adr[1] && wr_byte[1] == c[7:0], {tag, " R2 addr1"}, wr_byte[1], c[7:0]);
        check(wr_adr[2] && wr_byte[2] == {5'b0, c[10:8]}, {tag, " R2 addr2"}, wr_byte[2], c[10:8]);
        check(wr_adr[3] && wr_byte[3] == r[7:0], {tag, " R2 addr3"}, wr_byte[3], r[7:0]);
        check(wr_adr[4] && wr_byte[4] == r[15:8], {tag, " R2 addr4"}, wr_byte[4], r[15:8]);
        check(wr_cmd[5] && wr_byte[5] == 8'h30, {tag, " R2 confirm cmd"}, wr_byte[5], 8'h30);
        check(rx_n == exp_n, {tag, " R6 word count"}, rx_n, exp_n);
        check(rx_bad == 0, {tag, " R5 word values"}, rx_bad, 0);
        check(re_cnt == exp_n, {tag, " R5 strobe per word"}, re_cnt, exp_n);
        if (stall) check(hold_bad == 0, {tag, " R5 hold under backpressure"}, hold_bad, 0);
    endtask

    task automatic t_erase(input logic [15:0] r, input bit f, input int lag);
        m_fail = f; stat_lag = lag;
        start_op(2'd1, r, 11'd0, 11'd0);
        collect(r, 11'd0, 1'b0);
        check(wr_n == 5, "R7 erase write count", wr_n, 5);
        check(wr_cmd[0] && wr_byte[0] == 8'h60, "R7 erase setup", wr_byte[0], 8'h60);
        check(wr_adr[1] && wr_byte[1] == r[7:0], "R7 erase row lo", wr_byte[1], r[7:0]);
        check(wr_adr[2] && wr_byte[2] == r[15:8], "R7 erase row hi", wr_byte[2], r[15:8]);
        check(wr_cmd[3] && wr_byte[3] == 8'hD0, "R7 erase confirm", wr_byte[3], 8'hD0);
        check(wr_cmd[4] && wr_byte[4] == 8'h70, "R7 status cmd", wr_byte[4], 8'h70);
        check(fail == f, "R7 pass/fail bit", fail, f);
        check(re_cnt == lag + 1, "R8 status polls", re_cnt, lag + 1);
        check(rx_n == 0, "R7 erase emits no stream word", rx_n, 0);
        stat_lag = 0;
    endtask

    task automatic t_status(input bit f);
        m_fail = f;
        start_op(2'd2, 16'h0, 11'd0, 11'd0);
        collect(16'h0, 11'd0, 1'b0);
        check(wr_n == 1 && wr_cmd[0] && wr_byte[0] == 8'h70, "R9 status cmd", wr_byte[0], 8'h70);
        check(rx_n == 1, "R9 one status word", rx_n, 1);
        check(rx_last == {8'h00, 8'h40 | {7'b0, f}}, "R9 status word", rx_last, {8'h40 | {7'b0, f}});
        check(fail == f, "R9 fail bit", fail, f);
        check(re_cnt == 1, "R9 single strobe", re_cnt, 1);
    endtask

    task automatic t_ignore();
        // reserved op code
        start_op(2'd3, 16'h1234, 11'd0, 11'd1);
        repeat (20) @(negedge clk);
        check(!busy && wr_n == 0, "R10 reserved op ignored", wr_n, 0);
        // start while busy
        start_op(2'd0, 16'h0042, 11'd7, 11'd3);
        repeat (4) @(negedge clk);
        start = 1'b1; op = 2'd1; row = 16'hFFFF;
        @(negedge clk);
        start = 1'b0; row = 16'h0042; col = 11'd7; op = 2'd0;
        collect(16'h0042, 11'd7, 1'b0);
        check(wr_n == 6 && wr_byte[0] == 8'h00, "R10 busy start ignored", wr_n, 6);
        check(rx_n == 3 && rx_bad == 0, "R10 read unaffected", rx_n, 3);
        repeat (10) @(negedge clk);
        check(!busy && wr_n == 6, "R10 no queued request", wr_n, 6);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #3000000;
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_powerup();
        t_read(16'h0123, 11'd5, 11'd4, 1'b0, "basic");
        t_read(16'hA5C3, 11'd1052, 11'd10, 1'b0, "page end");
        t_read(16'h0007, 11'd0, 11'd0, 1'b0, "zero count");
        t_read(16'h3FC0, 11'd300, 11'd6, 1'b1, "stalled");
        t_erase(16'h0440, 1'b0, 0);
        t_erase(16'h8F80, 1'b1, 2);
        t_status(1'b1);
        t_status(1'b0);
        t_ignore();
        check(hi_viol == 0, "R3 upper byte/enable on writes", hi_viol, 0);
        check(tim_viol == 0, "R3 write cycle time", tim_viol, 0);
        check(re_early == 0, "R4 strobe while busy", re_early, 0);
        check(both_ctl == 0, "R11 latch strobes overlap", both_ctl, 0);
        check(oe_re == 0, "R11 bus contention", oe_re, 0);
        check(ar_viol == 0, "R11 latch-to-read gap", ar_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule